// File: doc/BRIEF.md
# SMBus Host Transaction Sequencer

This block turns one SMBus command request into the ordered series of bus primitives that a byte-level I2C master engine executes. It sits directly above that engine. A requester presents a command type, a direction bit, a 7-bit target address, a command code, a write length and a write payload, and pulses a start strobe. The sequencer then issues a start, address bytes, command and data bytes, a repeated start where the command reads data back, read primitives with the correct acknowledge policy, and a final stop. It issues one primitive at a time.

The sequencer supports quick commands, single-byte send and receive, byte-data and word-data reads and writes, the process call, and block read and block write. Words travel low byte first. For a block read, the first byte returned by the device sets the length of the read. Received bytes are collected in a buffer of up to `MAX_BYTES` entries. When the stop has completed, the block pulses `done`. It holds the received count, a not-acknowledge error flag and a protocol error flag until the next request is accepted.

The write payload is read live from `req_wdata` while the transaction runs, so the requester keeps it stable until `done`. `req_len` must lie between 1 and `MAX_BYTES` for a block write.

Top module: `smbus_seq`

## Requirements
- R1: Each primitive is requested by a one-cycle `eng_go` with `eng_op` coded 1 start, 2 repeated start, 3 write byte, 4 read with ACK, 5 read with NACK, 6 stop. A new `eng_go` appears only after `eng_done` has answered the previous one.
- R2: Every address byte is `{req_addr, dir}`, where dir 1 means read and dir 0 means write. The first address byte carries dir = `req_rnw` for a quick command (cmd 0) and for a single-byte command (cmd 1), and dir 0 for every other command. The address sent after a repeated start always carries dir 1.
- R3: A quick command (cmd 0) issues exactly: start, the address byte, stop.
- R4: A single-byte command (cmd 1) issues start and the address byte. If `req_rnw` is 0 it then writes payload byte 0. If `req_rnw` is 1 it reads one byte with NACK. A stop follows in both cases.
- R5: A byte-data write (cmd 2, rnw 0) sends the address, the command code and payload byte 0. A word-data write (cmd 3, rnw 0) sends the address, the command code, payload byte 0 (low) and payload byte 1 (high). Each write ends with a stop.
- R6: A byte-data read or word-data read (cmd 2 or cmd 3, rnw 1) runs in this order:
  1. Address with write direction, then the command code.
  2. Repeated start, then address with read direction.
  3. One or two reads, all ACKed except the last, which is NACKed.
  4. Stop.

  Read bytes land in buffer slots 0 and up, low byte first.
- R7: A process call (cmd 4) runs in this order:
  1. Address with write direction, the command code, payload byte 0 and payload byte 1.
  2. With no stop, a repeated start and address with read direction.
  3. Two reads (ACK, then NACK).
  4. Stop.
- R8: A block write (cmd 5, rnw 0) sends the address, the command code, a count byte equal to `req_len`, then payload bytes 0 to `req_len`-1, then a stop.
- R9: A block read (cmd 5, rnw 1) runs in this order:
  1. Address with write direction and the command code.
  2. Repeated start and address with read direction.
  3. A count read with ACK. When the count is between 1 and `MAX_BYTES`, exactly that many data reads follow, the last one NACKed.
  4. Stop.

  `rx_count` ends equal to the count.
- R10: A block read count of 0 or above `MAX_BYTES` sets `proto_err`. The next primitive is a single read with NACK, followed by a stop. No bytes are stored (`rx_count` = 0).
- R11: If `eng_nack` comes back on any write-byte primitive, the next primitive is a stop, `nack_err` is set, and the transaction ends.
- R12: `done` pulses for one cycle after the stop completes. A start strobe is ignored while `busy` or when `req_cmd` is above 5. Flags and `rx_count` are cleared when a request is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_start | input | 1 | Request strobe |
| req_cmd | input | 3 | Command type (0 quick, 1 byte, 2 byte-data, 3 word-data, 4 process call, 5 block) |
| req_rnw | input | 1 | Direction for commands that have both forms (1 = read) |
| req_addr | input | 7 | Target device address |
| req_code | input | 8 | Command code byte |
| req_len | input | CW | Block write byte count |
| req_wdata | input | MAX_BYTES*8 | Write payload, byte i at bits [8i+7:8i] |
| busy | output | 1 | Transaction in progress |
| done | output | 1 | One-cycle completion pulse |
| nack_err | output | 1 | Device did not acknowledge a host byte |
| proto_err | output | 1 | Block read count out of range |
| rx_count | output | CW | Number of bytes received |
| rx_data | output | MAX_BYTES*8 | Received bytes, byte i at bits [8i+7:8i] |
| eng_go | output | 1 | Primitive request to the engine |
| eng_op | output | 3 | Primitive code |
| eng_wdata | output | 8 | Byte for a write primitive |
| eng_done | input | 1 | Engine finished the outstanding primitive |
| eng_nack | input | 1 | Device NACKed the written byte (valid with eng_done) |
| eng_rdata | input | 8 | Byte read (valid with eng_done) |

## Verification
A wrong state register inside the sequencer shows up on the very next `eng_go`, one engine round trip later, as a wrong primitive code or a wrong byte. The bench therefore logs every primitive and compares the whole sequence against the expected order. A wrong byte index or length shows up as a misplaced NACK-read, a missing or extra data byte, or a stop arriving early or late. It also shows up in `rx_count` and `rx_data` at `done`. Error paths are exercised to confirm that a stop follows within one primitive and that the flags agree.

// File: rtl/smbus_seq.sv
module smbus_seq #(
  parameter int MAX_BYTES = 32,
  localparam int CW = $clog2(MAX_BYTES + 1)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   req_start,
  input  logic [2:0]             req_cmd,
  input  logic                   req_rnw,
  input  logic [6:0]             req_addr,
  input  logic [7:0]             req_code,
  input  logic [CW-1:0]          req_len,
  input  logic [MAX_BYTES*8-1:0] req_wdata,
  output logic                   busy,
  output logic                   done,
  output logic                   nack_err,
  output logic                   proto_err,
  output logic [CW-1:0]          rx_count,
  output logic [MAX_BYTES*8-1:0] rx_data,
  output logic                   eng_go,
  output logic [2:0]             eng_op,
  output logic [7:0]             eng_wdata,
  input  logic                   eng_done,
  input  logic                   eng_nack,
  input  logic [7:0]             eng_rdata
);

  localparam logic [2:0] OP_START = 3'd1, OP_RSTART = 3'd2, OP_WR = 3'd3,
                         OP_RDA = 3'd4, OP_RDN = 3'd5, OP_STOP = 3'd6;
  localparam logic [2:0] C_QUICK = 3'd0, C_BYTE = 3'd1, C_BDAT = 3'd2,
                         C_WDAT = 3'd3, C_PROC = 3'd4, C_BLK = 3'd5;

  typedef enum logic [3:0] {
    ST_IDLE, ST_START, ST_ADR1, ST_CODE, ST_WCNT, ST_WDAT,
    ST_RSTRT, ST_ADR2, ST_RCNT, ST_RDAT, ST_FLUSH, ST_STOP
  } st_t;

  st_t           st;
  logic          pend, rnw;
  logic [2:0]    cmd;
  logic [6:0]    addr;
  logic [7:0]    code;
  logic [CW-1:0] len, idx, n;
  logic          last, wr_st;

  assign busy   = (st != ST_IDLE);
  assign eng_go = busy && !pend;
  assign last   = (idx == n - CW'(1));
  assign wr_st  = (st == ST_ADR1) || (st == ST_CODE) || (st == ST_WCNT) ||
                  (st == ST_WDAT) || (st == ST_ADR2);

  always_comb begin
    eng_op    = 3'd0;
    eng_wdata = 8'd0;
    case (st)
      ST_START: eng_op = OP_START;
      ST_RSTRT: eng_op = OP_RSTART;
      ST_ADR1: begin
        eng_op    = OP_WR;
        eng_wdata = {addr, ((cmd == C_QUICK) || (cmd == C_BYTE)) ? rnw : 1'b0};
      end
      ST_CODE: begin eng_op = OP_WR; eng_wdata = code; end
      ST_WCNT: begin eng_op = OP_WR; eng_wdata = 8'(len); end
      ST_WDAT: begin eng_op = OP_WR; eng_wdata = req_wdata[idx*8 +: 8]; end
      ST_ADR2: begin eng_op = OP_WR; eng_wdata = {addr, 1'b1}; end
      ST_RCNT:  eng_op = OP_RDA;
      ST_RDAT:  eng_op = last ? OP_RDN : OP_RDA;
      ST_FLUSH: eng_op = OP_RDN;
      ST_STOP:  eng_op = OP_STOP;
      default:  eng_op = 3'd0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= ST_IDLE; pend <= 1'b0; cmd <= '0; rnw <= 1'b0; addr <= '0;
      code <= '0; len <= '0; idx <= '0; n <= '0; done <= 1'b0;
      nack_err <= 1'b0; proto_err <= 1'b0; rx_count <= '0; rx_data <= '0;
    end else begin
      done <= 1'b0;
      if (st == ST_IDLE) begin
        if (req_start && req_cmd <= C_BLK) begin
          cmd <= req_cmd; rnw <= req_rnw; addr <= req_addr; code <= req_code;
          len <= req_len; idx <= '0; n <= '0; pend <= 1'b0;
          nack_err <= 1'b0; proto_err <= 1'b0; rx_count <= '0;
          st <= ST_START;
        end
      end else if (eng_go) begin
        pend <= 1'b1;
      end else if (pend && eng_done) begin
        pend <= 1'b0;
        if (wr_st && eng_nack) begin
          nack_err <= 1'b1;
          st       <= ST_STOP;
        end else begin
          case (st)
            ST_START: st <= ST_ADR1;
            ST_ADR1: begin
              idx <= '0;
              if (cmd == C_QUICK) st <= ST_STOP;
              else if (cmd == C_BYTE) begin
                n  <= CW'(1);
                st <= rnw ? ST_RDAT : ST_WDAT;
              end else st <= ST_CODE;
            end
            ST_CODE: begin
              idx <= '0;
              n   <= (cmd == C_BDAT) ? CW'(1) : (cmd == C_BLK) ? len : CW'(2);
              if (cmd == C_PROC)      st <= ST_WDAT;
              else if (rnw)           st <= ST_RSTRT;
              else if (cmd == C_BLK)  st <= ST_WCNT;
              else                    st <= ST_WDAT;
            end
            ST_WCNT: st <= (len == '0) ? ST_STOP : ST_WDAT;
            ST_WDAT: begin
              if (last) begin
                idx <= '0;
                st  <= (cmd == C_PROC) ? ST_RSTRT : ST_STOP;
              end else idx <= idx + CW'(1);
            end
            ST_RSTRT: st <= ST_ADR2;
            ST_ADR2: begin
              idx <= '0;
              st  <= (cmd == C_BLK) ? ST_RCNT : ST_RDAT;
            end
            ST_RCNT: begin
              if (eng_rdata == 8'd0 || int'(eng_rdata) > MAX_BYTES) begin
                proto_err <= 1'b1;
                st        <= ST_FLUSH;
              end else begin
                n  <= CW'(eng_rdata);
                st <= ST_RDAT;
              end
            end
            ST_RDAT: begin
              rx_data[idx*8 +: 8] <= eng_rdata;
              rx_count <= idx + CW'(1);
              if (last) st <= ST_STOP;
              else idx <= idx + CW'(1);
            end
            ST_FLUSH: st <= ST_STOP;
            ST_STOP: begin
              st   <= ST_IDLE;
              done <= 1'b1;
            end
            default: st <= ST_IDLE;
          endcase
        end
      end
    end
  end

  // R1: a request is never repeated back to back
  a_r1_single_issue: assert property (@(posedge clk) disable iff (!rst_n)
    eng_go |=> !eng_go);

  // R11: NACK on a written byte leads straight to a stop with the flag set
  a_r11_nack_stop: assert property (@(posedge clk) disable iff (!rst_n)
    (pend && eng_done && eng_nack && eng_op == OP_WR) |=>
      (eng_go && eng_op == OP_STOP && nack_err));

  // R10: a bad block count is followed by a NACKed read
  a_r10_flush_nack: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(proto_err) |-> (eng_go && eng_op == OP_RDN));

  // R10: the two error causes never coexist
  a_r10_err_excl: assert property (@(posedge clk) disable iff (!rst_n)
    !(nack_err && proto_err));

  // R12: done only follows a completed stop
  a_r12_done_after_stop: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(eng_done && eng_op == OP_STOP));

  // R9: received count stays in range
  a_r9_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
    int'(rx_count) <= MAX_BYTES);

endmodule

// File: tb/smbus_seq_bench.sv
`timescale 1ns/1ps
module smbus_seq_bench;
  localparam int MAXB = 32;
  localparam int CW = $clog2(MAXB + 1);
  localparam int START = 1, RST = 2, WR = 3, RDA = 4, RDN = 5, STOP = 6;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_start = 1'b0, req_rnw = 1'b0;
  logic [2:0] req_cmd = '0;
  logic [6:0] req_addr = '0;
  logic [7:0] req_code = '0;
  logic [CW-1:0] req_len = '0;
  logic [MAXB*8-1:0] req_wdata = '0;
  logic busy, done, nack_err, proto_err, eng_go;
  logic [CW-1:0] rx_count;
  logic [MAXB*8-1:0] rx_data;
  logic [2:0] eng_op;
  logic [7:0] eng_wdata;
  logic eng_done, eng_nack;
  logic [7:0] eng_rdata;

  smbus_seq #(.MAX_BYTES(MAXB)) u_smbus_seq (
    .clk(clk), .rst_n(rst_n), .req_start(req_start), .req_cmd(req_cmd),
    .req_rnw(req_rnw), .req_addr(req_addr), .req_code(req_code),
    .req_len(req_len), .req_wdata(req_wdata), .busy(busy), .done(done),
    .nack_err(nack_err), .proto_err(proto_err), .rx_count(rx_count),
    .rx_data(rx_data), .eng_go(eng_go), .eng_op(eng_op),
    .eng_wdata(eng_wdata), .eng_done(eng_done), .eng_nack(eng_nack),
    .eng_rdata(eng_rdata));

  always #4 clk = ~clk;

  int total = 0, bad = 0;
  bit finished = 0;
  int op_log[0:79], dat_log[0:79], log_n = 0;
  int e_op[0:79], e_dat[0:79], e_n = 0;
  logic [7:0] rd_q[0:39];
  int rd_i = 0, wr_i = 0, nack_at = -1, cnt = 0;
  bit overlap = 0;
  int last_op = 0;

  // engine model: answers each primitive two cycles after it is seen
  initial begin
    eng_done = 1'b0; eng_nack = 1'b0; eng_rdata = 8'd0;
    forever begin
      @(negedge clk);
      if (eng_done) begin eng_done = 1'b0; eng_nack = 1'b0; end
      if (cnt > 0) begin
        if (eng_go) overlap = 1;
        cnt--;
        if (cnt == 0) begin
          if (last_op == WR) begin
            eng_nack = (wr_i == nack_at);
            wr_i++;
          end else if (last_op == RDA || last_op == RDN) begin
            eng_rdata = rd_q[rd_i];
            rd_i++;
          end
          eng_done = 1'b1;
        end
      end else if (eng_go) begin
        if (log_n < 80) begin
          op_log[log_n]  = int'(eng_op);
          dat_log[log_n] = int'(eng_wdata);
          log_n++;
        end
        last_op = int'(eng_op);
        cnt = 2;
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog: act=expired exp=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: act=%0d exp=%0d", req, act, exp);
    end
  endtask

  task automatic e_clr(); e_n = 0; endtask
  task automatic ex(input int op, input int dat);
    e_op[e_n] = op; e_dat[e_n] = dat; e_n++;
  endtask

  task automatic run(input int cmd, input bit rnw, input int addr, input int code,
                     input int len, input bit mid, input bit x_nack,
                     input bit x_proto, input string req);
    int k = 0;
    int mis = -1;
    log_n = 0; rd_i = 0; wr_i = 0; overlap = 0;
    @(negedge clk);
    req_cmd = 3'(cmd); req_rnw = rnw; req_addr = 7'(addr);
    req_code = 8'(code); req_len = CW'(len); req_start = 1'b1;
    @(negedge clk);
    req_start = 1'b0;
    while (!done && k < 5000) begin
      @(negedge clk);
      k++;
      if (mid && k == 6) begin req_start = 1'b1; req_cmd = 3'd0; end
      else req_start = 1'b0;
    end
    req_start = 1'b0;
    chk(done, {req, " done seen"}, int'(done), 1);
    @(negedge clk);
    chk(!done, "R12 done one cycle", int'(done), 0);
    chk(log_n == e_n, {req, " primitive count"}, log_n, e_n);
    for (int i = 0; i < e_n && i < log_n; i++)
      if (mis < 0 && (op_log[i] != e_op[i] || (e_dat[i] >= 0 && dat_log[i] != e_dat[i])))
        mis = i;
    if (mis >= 0)
      chk(0, {req, " primitive sequence"}, op_log[mis] * 256 + dat_log[mis],
          e_op[mis] * 256 + (e_dat[mis] < 0 ? 0 : e_dat[mis]));
    else chk(1, req, 0, 0);
    chk(nack_err == x_nack, {req, " R11 nack flag"}, int'(nack_err), int'(x_nack));
    chk(proto_err == x_proto, {req, " R10 proto flag"}, int'(proto_err), int'(x_proto));
    chk(!overlap, "R1 one outstanding primitive", int'(overlap), 0);
  endtask

  task automatic chk_rx(input int count, input string req);
    chk(int'(rx_count) == count, {req, " rx_count"}, int'(rx_count), count);
    for (int i = 0; i < count; i++)
      chk(rx_data[i*8 +: 8] == rd_q[i + ((req_cmd == 3'd5) ? 1 : 0)],
          {req, " rx byte"}, int'(rx_data[i*8 +: 8]),
          int'(rd_q[i + ((req_cmd == 3'd5) ? 1 : 0)]));
  endtask

  task automatic t_reset();
    chk(!busy && !eng_go && !done, "R12 reset idle", int'(busy), 0);
    chk(rx_count == '0 && !nack_err && !proto_err, "R12 reset flags", int'(rx_count), 0);
  endtask

  task automatic t_quick();
    e_clr(); ex(START, -1); ex(WR, 8'h54); ex(STOP, -1);
    run(0, 0, 7'h2A, 0, 0, 0, 0, 0, "R3 quick write R2");
    e_clr(); ex(START, -1); ex(WR, 8'h23); ex(STOP, -1);
    run(0, 1, 7'h11, 0, 0, 0, 0, 0, "R3 quick dir1 R2");
  endtask

  task automatic t_byte();
    rd_q[0] = 8'hA5;
    e_clr(); ex(START, -1); ex(WR, 8'h21); ex(RDN, -1); ex(STOP, -1);
    run(1, 1, 7'h10, 0, 0, 0, 0, 0, "R4 receive byte");
    chk_rx(1, "R4");
    req_wdata[7:0] = 8'h3C;
    e_clr(); ex(START, -1); ex(WR, 8'h20); ex(WR, 8'h3C); ex(STOP, -1);
    run(1, 0, 7'h10, 0, 0, 0, 0, 0, "R4 send byte");
  endtask

  task automatic t_writes();
    req_wdata[15:0] = 16'h1299;
    e_clr(); ex(START, -1); ex(WR, 8'h90); ex(WR, 8'h07); ex(WR, 8'h99); ex(STOP, -1);
    run(2, 0, 7'h48, 8'h07, 0, 0, 0, 0, "R5 byte data write");
    req_wdata[15:0] = 16'h1234;
    e_clr(); ex(START, -1); ex(WR, 8'h90); ex(WR, 8'h08); ex(WR, 8'h34);
    ex(WR, 8'h12); ex(STOP, -1);
    run(3, 0, 7'h48, 8'h08, 0, 0, 0, 0, "R5 word write low first");
  endtask

  task automatic t_reads();
    rd_q[0] = 8'h5E;
    e_clr(); ex(START, -1); ex(WR, 8'h90); ex(WR, 8'h05); ex(RST, -1);
    ex(WR, 8'h91); ex(RDN, -1); ex(STOP, -1);
    run(2, 1, 7'h48, 8'h05, 0, 0, 0, 0, "R6 byte data read R2");
    chk_rx(1, "R6");
    rd_q[0] = 8'hCD; rd_q[1] = 8'hAB;
    e_clr(); ex(START, -1); ex(WR, 8'h90); ex(WR, 8'h06); ex(RST, -1);
    ex(WR, 8'h91); ex(RDA, -1); ex(RDN, -1); ex(STOP, -1);
    run(3, 1, 7'h48, 8'h06, 0, 0, 0, 0, "R6 word read");
    chk_rx(2, "R6");
  endtask

  task automatic t_proc();
    req_wdata[15:0] = 16'hBEEF;
    rd_q[0] = 8'h01; rd_q[1] = 8'h80;
    e_clr(); ex(START, -1); ex(WR, 8'hA0); ex(WR, 8'h33); ex(WR, 8'hEF);
    ex(WR, 8'hBE); ex(RST, -1); ex(WR, 8'hA1); ex(RDA, -1); ex(RDN, -1); ex(STOP, -1);
    run(4, 0, 7'h50, 8'h33, 0, 1, 0, 0, "R7 process call R12 busy strobe");
    chk_rx(2, "R7");
  endtask

  task automatic t_blk_wr();
    req_wdata[23:0] = 24'hC3B2A1;
    e_clr(); ex(START, -1); ex(WR, 8'h6C); ex(WR, 8'h40); ex(WR, 3);
    ex(WR, 8'hA1); ex(WR, 8'hB2); ex(WR, 8'hC3); ex(STOP, -1);
    run(5, 0, 7'h36, 8'h40, 3, 0, 0, 0, "R8 block write");
  endtask

  task automatic t_blk_rd(input int c);
    rd_q[0] = 8'(c);
    for (int i = 1; i <= c; i++) rd_q[i] = 8'(i * 7 + 3);
    e_clr(); ex(START, -1); ex(WR, 8'h6C); ex(WR, 8'h41); ex(RST, -1);
    ex(WR, 8'h6D); ex(RDA, -1);
    for (int i = 1; i <= c; i++) ex((i == c) ? RDN : RDA, -1);
    ex(STOP, -1);
    run(5, 1, 7'h36, 8'h41, 0, 0, 0, 0, "R9 block read");
    chk_rx(c, "R9");
  endtask

  task automatic t_blk_bad(input int c);
    rd_q[0] = 8'(c); rd_q[1] = 8'h77;
    e_clr(); ex(START, -1); ex(WR, 8'h6C); ex(WR, 8'h42); ex(RST, -1);
    ex(WR, 8'h6D); ex(RDA, -1); ex(RDN, -1); ex(STOP, -1);
    run(5, 1, 7'h36, 8'h42, 0, 0, 0, 1, "R10 bad block count");
    chk(rx_count == '0, "R10 no bytes stored", int'(rx_count), 0);
  endtask

  task automatic t_nack();
    nack_at = 0;
    e_clr(); ex(START, -1); ex(WR, 8'h90); ex(STOP, -1);
    run(2, 0, 7'h48, 8'h07, 0, 0, 1, 0, "R11 nack on address");
    nack_at = 3;
    req_wdata[23:0] = 24'h030201;
    e_clr(); ex(START, -1); ex(WR, 8'h6C); ex(WR, 8'h40); ex(WR, 3);
    ex(WR, 8'h01); ex(STOP, -1);
    run(5, 0, 7'h36, 8'h40, 3, 0, 1, 0, "R11 nack on data");
    nack_at = -1;
    e_clr(); ex(START, -1); ex(WR, 8'h54); ex(STOP, -1);
    run(0, 0, 7'h2A, 0, 0, 0, 0, 0, "R12 flags cleared on new request");
  endtask

  task automatic t_bad_cmd();
    log_n = 0;
    @(negedge clk);
    req_cmd = 3'd7; req_start = 1'b1;
    @(negedge clk);
    req_start = 1'b0;
    repeat (20) @(negedge clk);
    chk(log_n == 0 && !busy, "R12 invalid command ignored", log_n, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    t_reset();
    t_quick();
    t_byte();
    t_writes();
    t_reads();
    t_proc();
    t_blk_wr();
    t_blk_rd(4);
    t_blk_rd(MAXB);
    t_blk_bad(0);
    t_blk_bad(MAXB + 1);
    t_nack();
    t_bad_cmd();
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule